// File: doc/BRIEF.md
# Multimapped Physical Register Allocator

This block hands out physical registers to a rename stage whose register file is split into banks. Each rename request receives a main register. When the pool still holds a register in some other bank, the request also receives an auxiliary register there. Later reads of that value can then go to whichever of the two banks has a free read port. The pool is a set of per-bank free bitmaps. Beside it sits a mapping table with one entry per physical register, holding a main-held bit, an auxiliary-attached bit and the auxiliary index.

If the pool runs dry, the allocator takes back an auxiliary register from an existing mapping and grants it as the new main register. Only when no mapping carries an auxiliary register does it report a stall. Releasing a main register returns it to the pool, together with any auxiliary register attached to it. A separate drop request takes back only the auxiliary register. The writeback stage uses it when it could not find a write port for the second copy.

One request is accepted per cycle. The allocation result appears on the response outputs in the cycle after the request.

Top module: `mm_reg_alloc`

## Requirements
- R1: After reset every physical register is free, no mapping exists and all response outputs are 0. The first allocation returns main index 0 with auxiliary index 1.
- R2: A physical index i lies in bank i mod 4 (96 registers, 4 banks). The main register comes from the first bank holding a free register, scanning upward with wrap-around from a start bank. The start bank is 0 after reset and becomes (main bank + 1) mod 4 after each grant taken from the pool. Within the chosen bank, the lowest free index is taken.
- R3: After a main grant from the pool, an auxiliary register is taken from the first non-empty bank that follows the main bank in wrap-around order, never from the main bank itself, at its lowest free index. If no other bank has a free register, rsp_aux_valid is 0 and rsp_aux is 0.
- R4: req_op encodes 0 idle, 1 allocate, 2 free, 3 drop auxiliary. An allocate sampled at a clock edge produces rsp_valid = 1 for exactly the following cycle. Any other request leaves rsp_valid at 0.
- R5: When the pool is empty, an allocate takes the lowest-indexed main register that has an auxiliary attached, detaches it and grants that auxiliary index as the main register. The response shows rsp_reclaim = 1 and no auxiliary register. A later free of the old main returns only that main.
- R6: When the pool is empty and no mapping carries an auxiliary register, an allocate answers with rsp_stall = 1 and rsp_main = 0, and changes no state.
- R7: A free of a held main register returns it to the pool, together with its attached auxiliary register if one exists. Both can then be granted again.
- R8: A drop on a held main register returns only its auxiliary register to the pool. The main stays held, and a later free returns only the main.
- R9: A free or drop naming an index that is not currently held as a main register, including indices of 96 and above, is ignored. A drop on a main without an auxiliary register is also ignored.
- R10: No index is granted while it is still held as a main or auxiliary register, and the number of free plus held registers always equals 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | Request code: 0 idle, 1 allocate, 2 free, 3 drop auxiliary |
| req_idx | input | 7 | Main register named by a free or drop request |
| rsp_valid | output | 1 | Allocation response present this cycle |
| rsp_stall | output | 1 | Allocation could not be served |
| rsp_reclaim | output | 1 | Main register was taken back from an auxiliary mapping |
| rsp_main | output | 7 | Granted main register index |
| rsp_aux_valid | output | 1 | An auxiliary register was granted |
| rsp_aux | output | 7 | Granted auxiliary register index |

## Verification
The bench drains the pool completely, so every allocation in turn exercises the aux-from-other-bank path, the path where only one bank remains and no auxiliary is granted, the reclaim path and the stall path. An allocator that drew the auxiliary from the main bank would break the bank separation, and one that reclaimed the wrong entry would hand out an index the model still counts as held. Directed cases free the same main register twice and drop an auxiliary register twice. A design that double-returned an index would then grant one register to two owners, and one that ignored the drop would stall where the model expects a grant. Long random runs with a fixed seed then mix allocation, free, drop and bogus requests, checking each grant against a rotating-scan model.

// File: rtl/mm_alloc_pkg.sv
package mm_alloc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ALLOC = 2'd1,
    OP_FREE  = 2'd2,
    OP_DROP  = 2'd3
  } op_e;

  // physical index from bank-local slot and bank number
  function automatic int unsigned compose_idx(input int unsigned slot,
                                              input int unsigned bank,
                                              input int unsigned nb);
    return slot * nb + bank;
  endfunction

  function automatic int unsigned bank_of(input int unsigned idx,
                                          input int unsigned nb);
    return idx % nb;
  endfunction

  function automatic int unsigned slot_of(input int unsigned idx,
                                          input int unsigned nb);
    return idx / nb;
  endfunction

endpackage

// File: rtl/mm_bank_freelist.sv
module mm_bank_freelist #(
  parameter int SLOTS = 24,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             put_a,
  input  logic [SW-1:0]    put_a_slot,
  input  logic             put_b,
  input  logic [SW-1:0]    put_b_slot,
  output logic             nonempty,
  output logic [SW-1:0]    low_slot,
  output logic [SLOTS-1:0] free_vec
);

  logic [SLOTS-1:0] free_q;

  // lowest free slot of this bank
  always_comb begin
    low_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_q[i]) low_slot = SW'(i);
    end
  end

  assign nonempty = |free_q;
  assign free_vec = free_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= '1;
    end else begin
      if (take)  free_q[low_slot]   <= 1'b0;
      if (put_a) free_q[put_a_slot] <= 1'b1;
      if (put_b) free_q[put_b_slot] <= 1'b1;
    end
  end

endmodule

// File: rtl/mm_rot_pick.sv
module mm_rot_pick #(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0] avail,
  input  logic [BW-1:0] start,
  output logic          found,
  output logic [BW-1:0] pick
);

  // first available bank at or after start, wrapping
  always_comb begin
    pick = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (avail[(int'(start) + k) % NB]) pick = BW'((int'(start) + k) % NB);
    end
  end

  assign found = |avail;

endmodule

// File: rtl/mm_aux_scan.sv
module mm_aux_scan #(
  parameter int NREG = 96,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] has_aux,
  output logic            found,
  output logic [IW-1:0]   ent
);

  // lowest-index entry that carries an auxiliary register
  always_comb begin
    ent = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (has_aux[i]) ent = IW'(i);
    end
  end

  assign found = |has_aux;

endmodule

// File: rtl/mm_reg_alloc.sv
module mm_reg_alloc
  import mm_alloc_pkg::*;
#(
  parameter int NREG = 96,
  parameter int NB = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_op,
  input  logic [IW-1:0] req_idx,
  output logic          rsp_valid,
  output logic          rsp_stall,
  output logic          rsp_reclaim,
  output logic [IW-1:0] rsp_main,
  output logic          rsp_aux_valid,
  output logic [IW-1:0] rsp_aux
);

  localparam int SLOTS = NREG / NB;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  // mapping table
  logic [NREG-1:0] mv_q;
  logic [NREG-1:0] ia_q;
  logic [IW-1:0]   ra_q [NREG];
  logic [BW-1:0]   rr_q;

  // per-bank pool view
  logic [NB-1:0]    bank_ne;
  logic [SW-1:0]    bank_low [NB];
  logic [SLOTS-1:0] bank_fv  [NB];
  logic [NB-1:0]    take_v, pa_v, pb_v;

  // decoded request
  logic is_alloc, is_free, is_drop;
  assign is_alloc = (req_op == OP_ALLOC);
  assign is_free  = (req_op == OP_FREE);
  assign is_drop  = (req_op == OP_DROP);

  logic          idx_ok;
  logic [IW-1:0] req_ent;
  logic          held_main;
  assign idx_ok    = (int'(req_idx) < NREG);
  assign req_ent   = idx_ok ? req_idx : '0;
  assign held_main = idx_ok && mv_q[req_ent];

  // main bank choice
  logic          main_found;
  logic [BW-1:0] main_bank;
  mm_rot_pick #(.NB(NB)) u_main_pick (
    .avail (bank_ne),
    .start (rr_q),
    .found (main_found),
    .pick  (main_bank)
  );

  // auxiliary bank choice, main bank masked out
  logic [NB-1:0] aux_avail;
  logic [BW-1:0] aux_start;
  logic          aux_found;
  logic [BW-1:0] aux_bank;
  always_comb begin
    aux_avail = bank_ne;
    aux_avail[main_bank] = 1'b0;
  end
  assign aux_start = BW'((int'(main_bank) + 1) % NB);
  mm_rot_pick #(.NB(NB)) u_aux_pick (
    .avail (aux_avail),
    .start (aux_start),
    .found (aux_found),
    .pick  (aux_bank)
  );

  // reclaim search
  logic          scan_found;
  logic [IW-1:0] scan_ent;
  mm_aux_scan #(.NREG(NREG)) u_scan (
    .has_aux (ia_q),
    .found   (scan_found),
    .ent     (scan_ent)
  );

  // named internal events
  logic          fire_list, fire_aux, fire_reclaim, fire_stall;
  logic          fire_free, fire_drop;
  logic [IW-1:0] main_idx_w, aux_idx_w, reclaim_idx_w;
  logic          put_main_en, put_aux_en;
  logic [IW-1:0] put_main_idx, put_aux_idx;

  assign fire_list    = is_alloc && main_found;
  assign fire_aux     = fire_list && aux_found;
  assign fire_reclaim = is_alloc && !main_found && scan_found;
  assign fire_stall   = is_alloc && !main_found && !scan_found;
  assign fire_free    = is_free && held_main;
  assign fire_drop    = is_drop && held_main && ia_q[req_ent];

  assign main_idx_w    = IW'(compose_idx(int'(bank_low[main_bank]), int'(main_bank), NB));
  assign aux_idx_w     = IW'(compose_idx(int'(bank_low[aux_bank]), int'(aux_bank), NB));
  assign reclaim_idx_w = ra_q[scan_ent];

  assign put_main_en  = fire_free;
  assign put_main_idx = req_ent;
  assign put_aux_en   = (fire_free && ia_q[req_ent]) || fire_drop;
  assign put_aux_idx  = ra_q[req_ent];

  logic [SW-1:0] pa_slot, pb_slot;
  assign pa_slot = SW'(slot_of(int'(put_main_idx), NB));
  assign pb_slot = SW'(slot_of(int'(put_aux_idx), NB));

  // bank free lists
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign take_v[b] = (fire_list && int'(main_bank) == b) ||
                       (fire_aux  && int'(aux_bank)  == b);
    assign pa_v[b]   = put_main_en && (bank_of(int'(put_main_idx), NB) == b);
    assign pb_v[b]   = put_aux_en  && (bank_of(int'(put_aux_idx), NB) == b);
    mm_bank_freelist #(.SLOTS(SLOTS)) u_fl (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take_v[b]),
      .put_a      (pa_v[b]),
      .put_a_slot (pa_slot),
      .put_b      (pb_v[b]),
      .put_b_slot (pb_slot),
      .nonempty   (bank_ne[b]),
      .low_slot   (bank_low[b]),
      .free_vec   (bank_fv[b])
    );
  end

  // flat pool view for the checker
  logic [NREG-1:0] pool_free;
  for (genvar i = 0; i < NREG; i++) begin : g_pool
    assign pool_free[i] = bank_fv[i % NB][i / NB];
  end

  // table and start bank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv_q <= '0;
      ia_q <= '0;
      rr_q <= '0;
      for (int i = 0; i < NREG; i++) ra_q[i] <= '0;
    end else begin
      if (fire_list) begin
        mv_q[main_idx_w] <= 1'b1;
        ia_q[main_idx_w] <= fire_aux;
        ra_q[main_idx_w] <= fire_aux ? aux_idx_w : '0;
        rr_q <= aux_start;
      end
      if (fire_reclaim) begin
        ia_q[scan_ent]      <= 1'b0;
        mv_q[reclaim_idx_w] <= 1'b1;
        ia_q[reclaim_idx_w] <= 1'b0;
      end
      if (fire_free) begin
        mv_q[req_ent] <= 1'b0;
        ia_q[req_ent] <= 1'b0;
      end
      if (fire_drop) begin
        ia_q[req_ent] <= 1'b0;
      end
    end
  end

  // response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_stall     <= 1'b0;
      rsp_reclaim   <= 1'b0;
      rsp_main      <= '0;
      rsp_aux_valid <= 1'b0;
      rsp_aux       <= '0;
    end else begin
      rsp_valid     <= is_alloc;
      rsp_stall     <= fire_stall;
      rsp_reclaim   <= fire_reclaim;
      rsp_main      <= fire_list ? main_idx_w : (fire_reclaim ? reclaim_idx_w : '0);
      rsp_aux_valid <= fire_aux;
      rsp_aux       <= fire_aux ? aux_idx_w : '0;
    end
  end

endmodule

// File: rtl/mm_reg_alloc_chk.sv
module mm_reg_alloc_chk #(
  parameter int NREG = 96,
  parameter int NB = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      req_op,
  input logic            rsp_valid,
  input logic            rsp_stall,
  input logic            rsp_reclaim,
  input logic [IW-1:0]   rsp_main,
  input logic            rsp_aux_valid,
  input logic [IW-1:0]   rsp_aux,
  input logic            fire_list,
  input logic            fire_aux,
  input logic [IW-1:0]   main_idx_w,
  input logic [IW-1:0]   aux_idx_w,
  input logic            put_main_en,
  input logic [IW-1:0]   put_main_idx,
  input logic            put_aux_en,
  input logic [IW-1:0]   put_aux_idx,
  input logic [NREG-1:0] pool_free
);

  p_aux_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_aux_valid) |-> ((int'(rsp_main) % NB) != (int'(rsp_aux) % NB)));

  p_resp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 2'd1) |=> rsp_valid);

  p_resp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op != 2'd1) |=> !rsp_valid);

  p_reclaim_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reclaim |-> (rsp_valid && !rsp_aux_valid && !rsp_stall));

  p_stall_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (rsp_valid && !rsp_aux_valid && rsp_main == '0));

  p_put_main_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    put_main_en |-> !pool_free[put_main_idx]);

  p_put_aux_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    put_aux_en |-> !pool_free[put_aux_idx]);

  p_take_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_list |-> (pool_free[main_idx_w] && (!fire_aux || pool_free[aux_idx_w])));

  p_take_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_list |=> !pool_free[$past(main_idx_w)]);

endmodule

bind mm_reg_alloc mm_reg_alloc_chk #(.NREG(NREG), .NB(NB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_op        (req_op),
  .rsp_valid     (rsp_valid),
  .rsp_stall     (rsp_stall),
  .rsp_reclaim   (rsp_reclaim),
  .rsp_main      (rsp_main),
  .rsp_aux_valid (rsp_aux_valid),
  .rsp_aux       (rsp_aux),
  .fire_list     (fire_list),
  .fire_aux      (fire_aux),
  .main_idx_w    (main_idx_w),
  .aux_idx_w     (aux_idx_w),
  .put_main_en   (put_main_en),
  .put_main_idx  (put_main_idx),
  .put_aux_en    (put_aux_en),
  .put_aux_idx   (put_aux_idx),
  .pool_free     (pool_free)
);

// File: tb/mm_reg_alloc_test.sv
`timescale 1ns/1ps
module mm_reg_alloc_test;

  localparam int NREG = 96;
  localparam int NB = 4;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [IW-1:0] req_idx = '0;
  logic          rsp_valid, rsp_stall, rsp_reclaim, rsp_aux_valid;
  logic [IW-1:0] rsp_main, rsp_aux;

  always #2.5 clk = ~clk;

  mm_reg_alloc #(.NREG(NREG), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_reclaim(rsp_reclaim),
    .rsp_main(rsp_main), .rsp_aux_valid(rsp_aux_valid), .rsp_aux(rsp_aux)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  bit m_free [NREG];
  bit m_main [NREG];
  bit m_haux [NREG];
  int m_aux  [NREG];
  int m_start;

  function automatic int lowest_in(input int b);
    for (int i = b; i < NREG; i += NB) if (m_free[i]) return i;
    return -1;
  endfunction

  function automatic int first_reclaim();
    for (int e = 0; e < NREG; e++) if (m_haux[e]) return e;
    return -1;
  endfunction

  function automatic int held_total();
    int n = 0;
    for (int i = 0; i < NREG; i++) begin
      if (m_main[i]) n++;
      if (m_haux[i]) n++;
    end
    return n;
  endfunction

  function automatic int free_total();
    int n = 0;
    for (int i = 0; i < NREG; i++) if (m_free[i]) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic predict(output bit xs, output bit xr, output int xm,
                         output bit xav, output int xa);
    int mb;
    mb = -1; xs = 0; xr = 0; xm = 0; xav = 0; xa = 0;
    for (int k = 0; k < NB; k++) begin
      if (mb < 0 && lowest_in((m_start + k) % NB) >= 0) mb = (m_start + k) % NB;
    end
    if (mb >= 0) begin
      xm = lowest_in(mb);
      for (int k = 1; k < NB; k++) begin
        if (!xav && lowest_in((mb + k) % NB) >= 0) begin
          xav = 1;
          xa = lowest_in((mb + k) % NB);
        end
      end
    end else if (first_reclaim() >= 0) begin
      xr = 1;
      xm = m_aux[first_reclaim()];
    end else begin
      xs = 1;
    end
  endtask

  task automatic run(input logic [1:0] op, input int idx, input string tag);
    bit xs, xr, xav;
    int xm, xa, e;
    req_op = op;
    req_idx = IW'(idx);
    xs = 0; xr = 0; xav = 0; xm = 0; xa = 0;
    if (op == 2'd1) predict(xs, xr, xm, xav, xa);
    @(negedge clk);
    if (op == 2'd1) begin
      check(rsp_valid && rsp_stall == xs && rsp_reclaim == xr &&
            int'(rsp_main) == xm && rsp_aux_valid == xav && int'(rsp_aux) == xa, tag,
            $sformatf("got v=%0d s=%0d r=%0d m=%0d av=%0d a=%0d exp v=1 s=%0d r=%0d m=%0d av=%0d a=%0d",
                      rsp_valid, rsp_stall, rsp_reclaim, rsp_main, rsp_aux_valid, rsp_aux,
                      xs, xr, xm, xav, xa));
      if (!xs && !xr)
        check(m_free[int'(rsp_main)] && (!rsp_aux_valid || m_free[int'(rsp_aux)]), "R10",
              $sformatf("granted held index main=%0d aux=%0d exp free indices", rsp_main, rsp_aux));
      // commit
      if (xr) begin
        e = first_reclaim();
        m_haux[e] = 0;
        m_main[xm] = 1;
        m_haux[xm] = 0;
      end else if (!xs) begin
        m_free[xm] = 0;
        m_main[xm] = 1;
        m_haux[xm] = xav;
        m_aux[xm] = xa;
        if (xav) m_free[xa] = 0;
        m_start = (xm % NB + 1) % NB;
      end
    end else begin
      check(!rsp_valid, "R4", $sformatf("got rsp_valid=%0d exp 0", rsp_valid));
      if (idx < NREG && m_main[idx]) begin
        if (op == 2'd2) begin
          m_free[idx] = 1;
          m_main[idx] = 0;
          if (m_haux[idx]) m_free[m_aux[idx]] = 1;
          m_haux[idx] = 0;
        end else if (op == 2'd3 && m_haux[idx]) begin
          m_free[m_aux[idx]] = 1;
          m_haux[idx] = 0;
        end
      end
    end
    req_op = 2'd0;
  endtask

  function automatic int pick_held(input int from);
    for (int k = 0; k < NREG; k++) if (m_main[(from + k) % NREG]) return (from + k) % NREG;
    return -1;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish_run();
  end

  initial begin
    int x, y, r;
    bit xs, xr, xav;
    int xm, xa;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) begin
      m_free[i] = 1; m_main[i] = 0; m_haux[i] = 0; m_aux[i] = 0;
    end
    m_start = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !rsp_stall && !rsp_reclaim && !rsp_aux_valid &&
          rsp_main == 0 && rsp_aux == 0, "R1",
          $sformatf("got v=%0d s=%0d r=%0d m=%0d av=%0d a=%0d exp all 0",
                    rsp_valid, rsp_stall, rsp_reclaim, rsp_main, rsp_aux_valid, rsp_aux));

    // R1: first grant is main 0, aux 1
    run(2'd1, 0, "R1");
    run(2'd0, 0, "R4");

    // R2/R3: drain the pool with aux grants
    for (int n = 0; n < 60 && free_total() > 0; n++) run(2'd1, 0, "R3");
    check(free_total() == 0, "R2", $sformatf("got free=%0d exp 0", free_total()));

    // R5: reclaim until no aux left
    for (int n = 0; n < 100 && first_reclaim() >= 0; n++) run(2'd1, 0, "R5");
    check(held_total() == NREG, "R10", $sformatf("got held=%0d exp %0d", held_total(), NREG));

    // R6: stall, twice, no state change
    run(2'd1, 0, "R6");
    run(2'd1, 0, "R6");

    // R7: free one main, it comes back without aux (single bank left)
    x = pick_held(10);
    run(2'd2, x, "R7");
    run(2'd1, 0, "R7");
    check(int'(rsp_main) == x && !rsp_aux_valid, "R3",
          $sformatf("got m=%0d av=%0d exp m=%0d av=0", rsp_main, rsp_aux_valid, x));

    // R9: double free
    x = pick_held(20);
    run(2'd2, x, "R9");
    run(2'd2, x, "R9");
    run(2'd1, 0, "R9");
    run(2'd1, 0, "R9");
    check(rsp_stall, "R9", $sformatf("got stall=%0d exp 1 after double free", rsp_stall));
    run(2'd2, 127, "R9");
    run(2'd1, 0, "R9");

    // R8: drop an auxiliary register
    x = pick_held(0);
    y = pick_held(x + 1);
    while ((y % NB) == (x % NB)) y = pick_held(y + 1);
    run(2'd2, x, "R8");
    run(2'd2, y, "R8");
    predict(xs, xr, xm, xav, xa);
    run(2'd1, 0, "R8");
    check(xav, "R8", $sformatf("got aux predicted=%0d exp 1", xav));
    run(2'd3, xm, "R8");
    run(2'd1, 0, "R8");
    check(int'(rsp_main) == xa, "R8", $sformatf("got m=%0d exp %0d", rsp_main, xa));
    run(2'd3, xm, "R9");
    run(2'd1, 0, "R9");
    check(rsp_stall, "R9", $sformatf("got stall=%0d exp 1 after repeated drop", rsp_stall));

    // random mix
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      if (r < 42) run(2'd1, 0, "R2");
      else if (r < 72) begin
        x = pick_held(int'($urandom % NREG));
        run(2'd2, (x < 0) ? 0 : x, "R7");
      end else if (r < 84) begin
        x = pick_held(int'($urandom % NREG));
        run(2'd3, (x < 0) ? 0 : x, "R8");
      end else if (r < 92) run(2'd2, int'($urandom % 128), "R9");
      else run(2'd0, 0, "R4");
    end
    check(free_total() + held_total() == NREG, "R10",
          $sformatf("got free+held=%0d exp %0d", free_total() + held_total(), NREG));
    finish_run();
  end

endmodule